// File: doc/BRIEF.md
# Host Interrupt Request Generator

This block drives three host interrupt lines from an embedded controller: one for the keyboard channel, one for the mouse channel and one for the power-management channel. For each line a select input picks the source. Under hardware control the line follows events from its channel's output buffer. Under firmware control the line copies a bit that firmware writes into the block's control register.

The same 8-bit control register also sets the signalling style for all hardware-driven lines. A 3-bit mode field chooses level signalling or a one-shot pulse of 1, 2, 4, 8 or 16 clock cycles. A polarity bit inverts both styles. When the register is read, its three low bits return the live levels of the three pins, not the stored firmware bits. Firmware can therefore watch the lines whichever source drives them.

All outputs are registered, and reset is synchronous and active high.

Top module: `host_irq_gen`

## Requirements
- R1: While `rst` is high, `irq_out` is 000 and `cfg_rdata` is 0x00. The control register resets to 0x07, so after reset with `hw_en`=000 all three lines go to 1 on the first clock edge.
- R2: Mode field `cfg[5:3]` selects the signalling style. 000 selects level mode. 001, 010, 011, 100 and 101 select pulse mode with widths of 1, 2, 4, 8 and 16 cycles respectively.
- R3: With polarity `cfg[6]`=0, a pulse-mode line idles at 1 and is driven to 0 during the pulse. With polarity 1, it idles at 0 and is driven to 1 during the pulse.
- R4: In level mode, a hardware-driven line equals `obf[i]` XOR `cfg[6]`, one clock edge after `obf` is sampled.
- R5: Line i is under firmware control when its select `hw_en[i]` is 0. The line then carries `cfg[i]`, with line 0 (keyboard) = bit 0, line 1 (mouse) = bit 1 and line 2 (power-management) = bit 2. A register write shows on the pin two clock edges after the write strobe is sampled.
- R6: Line 2 obeys its firmware bit only when `pm_compat`=1 and `hw_en[2]`=0. When `pm_compat`=0, line 2 is hardware driven whatever the value of `hw_en[2]`.
- R7: `cfg_rdata[2:0]` returns `irq_out[2:0]` whatever the select bits are. `cfg_rdata[6:3]` return the stored mode and polarity, and `cfg_rdata[7]` always reads 0.
- R8: A buffer write strobe that arrives while a pulse is active restarts the pulse. The line stays active for the full width counted from the latest strobe.
- R9: The reserved mode codes 110 and 111 are stored and read back, and the lines then behave as in level mode.
- R10: A pulse goes active on the clock edge that samples `obuf_wr[i]`=1. A single strobe gives exactly the selected number of active cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Control register write strobe |
| cfg_wdata | input | 8 | Control register write data |
| cfg_rdata | output | 8 | Read value: pin levels in bits 2:0, mode and polarity in bits 6:3 |
| hw_en | input | 3 | Per-line source select (1 = hardware, 0 = firmware bit) |
| pm_compat | input | 1 | Power-management channel is in compatible mode |
| obf | input | 3 | Per-channel output-buffer-full flags |
| obuf_wr | input | 3 | Per-channel output-buffer write strobes |
| irq_out | output | 3 | Host interrupt lines (0 keyboard, 1 mouse, 2 power-management) |

## Verification
Level-mode and pulse results are due on the clock edge that samples the stimulus. Firmware-bit results are due one edge after the register is updated, which makes two edges after the write strobe. The bench drives every input on a falling edge and samples on the next falling edge, so each sample lands a whole half cycle after the edge where the result is due. Pulse widths are measured by counting, at each falling edge, the samples that differ from the idle level over a window longer than the widest pulse. This catches both a late start and a wrong length.

// File: rtl/host_irq_pkg.sv
package host_irq_pkg;
  localparam int LINES   = 3;
  localparam int MAX_LOG = 4;            // widest pulse = 2**MAX_LOG cycles
  localparam int CNT_W   = MAX_LOG + 1;

  // Pulse width for a mode code; zero means level behaviour.
  function automatic logic [CNT_W-1:0] pulse_width(input logic [2:0] code);
    logic [CNT_W-1:0] w;
    w = '0;
    if (code != 3'd0 && int'(code) <= MAX_LOG + 1)
      w = CNT_W'(1) << (code - 3'd1);
    return w;
  endfunction
endpackage

// File: rtl/irq_ctrl_reg.sv
module irq_ctrl_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       wr,
  input  logic [7:0] wdata,
  output logic [2:0] fw_bits,
  output logic [2:0] mode,
  output logic       pol
);
  localparam logic [6:0] RESET_VAL = 7'h07;

  logic [6:0] ctrl_q;

  always_ff @(posedge clk) begin
    if (rst)     ctrl_q <= RESET_VAL;
    else if (wr) ctrl_q <= wdata[6:0];
  end

  assign fw_bits = ctrl_q[2:0];
  assign mode    = ctrl_q[5:3];
  assign pol     = ctrl_q[6];

  // R1: the register comes out of reset holding its default value
  a_r1_reset_value: assert property (@(posedge clk)
    $fell(rst) |-> (ctrl_q == RESET_VAL));
endmodule

// File: rtl/irq_line.sv
module irq_line #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             hw_sel,
  input  logic             fw_bit,
  input  logic             obf,
  input  logic             obuf_wr,
  input  logic [CNT_W-1:0] width,
  input  logic             pol,
  output logic             irq
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             pulse_mode, act, hw_val;

  assign pulse_mode = (width != '0);

  always_comb begin
    if (obuf_wr && pulse_mode) cnt_d = width;
    else if (cnt_q != '0)      cnt_d = cnt_q - 1'b1;
    else                       cnt_d = '0;
  end

  assign act    = (cnt_d != '0);
  assign hw_val = pulse_mode ? ~(act ^ pol) : (obf ^ pol);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      irq   <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      irq   <= hw_sel ? hw_val : fw_bit;
    end
  end

  // R10: a strobe in pulse mode makes the line active on the next edge
  a_r10_pulse_start: assert property (@(posedge clk) disable iff (rst)
    (obuf_wr && pulse_mode && hw_sel) |=> (irq == $past(pol)));

  // R5: firmware-controlled line copies its register bit
  a_r5_fw_follow: assert property (@(posedge clk) disable iff (rst)
    !hw_sel |=> (irq == $past(fw_bit)));

  // R8: the counter never exceeds the width it was loaded with
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    (pulse_mode && $stable(width)) |=> (cnt_q <= $past(width)));
endmodule

// File: rtl/host_irq_gen.sv
module host_irq_gen
  import host_irq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cfg_wr,
  input  logic [7:0] cfg_wdata,
  output logic [7:0] cfg_rdata,
  input  logic [2:0] hw_en,
  input  logic       pm_compat,
  input  logic [2:0] obf,
  input  logic [2:0] obuf_wr,
  output logic [2:0] irq_out
);
  logic [2:0]       fw_bits;
  logic [2:0]       mode;
  logic             pol;
  logic [CNT_W-1:0] width;
  logic [2:0]       hw_sel;

  irq_ctrl_reg u_reg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .wdata(cfg_wdata),
    .fw_bits(fw_bits), .mode(mode), .pol(pol)
  );

  assign width = pulse_width(mode);

  // Line 2 yields to firmware only in compatible mode.
  assign hw_sel = {hw_en[2] | ~pm_compat, hw_en[1:0]};

  for (genvar i = 0; i < LINES; i++) begin : g_line
    irq_line #(.CNT_W(CNT_W)) u_line (
      .clk(clk), .rst(rst), .hw_sel(hw_sel[i]), .fw_bit(fw_bits[i]),
      .obf(obf[i]), .obuf_wr(obuf_wr[i]), .width(width), .pol(pol),
      .irq(irq_out[i])
    );
  end

  assign cfg_rdata = {1'b0, pol, mode, irq_out};

  // R6: outside compatible mode line 2 never takes the firmware bit
  a_r6_pm_hw: assert property (@(posedge clk) disable iff (rst)
    (!pm_compat && width == '0) |=> (irq_out[2] == ($past(obf[2]) ^ $past(pol))));

  // R7: stored fields only change on a write
  a_r7_hold: assert property (@(posedge clk) disable iff (rst)
    !cfg_wr |=> $stable(cfg_rdata[7:3]));

  // R7: bit 7 always reads zero
  a_r7_bit7_zero: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[7] == 1'b0);
endmodule

// File: tb/sim_host_irq_gen.sv
module sim_host_irq_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = '0;
  logic [7:0] cfg_rdata;
  logic [2:0] hw_en = '0;
  logic       pm_compat = 1'b1;
  logic [2:0] obf = '0;
  logic [2:0] obuf_wr = '0;
  logic [2:0] irq_out;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  host_irq_gen u0 (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .hw_en(hw_en), .pm_compat(pm_compat),
    .obf(obf), .obuf_wr(obuf_wr), .irq_out(irq_out)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    cfg_wr = 1'b1; cfg_wdata = v;
    step();
    cfg_wr = 1'b0;
  endtask

  function automatic int exp_width(input int code);
    if (code >= 1 && code <= 5) return 1 << (code - 1);
    return 0;
  endfunction

  // Count samples of line 0 that differ from idle; strobes at listed steps.
  task automatic measure(input int second_wr, input logic idle, output int n);
    n = 0;
    for (int i = 0; i < 24; i++) begin
      obuf_wr[0] = (i == 0) || (i == second_wr);
      step();
      if (irq_out[0] != idle) n++;
    end
    obuf_wr = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int n;
    logic idle;
    @(negedge clk);
    step();
    // R1 reset state
    check("R1 irq during reset", irq_out, 0);
    check("R1 rdata during reset", cfg_rdata, 8'h00);
    rst = 1'b0;
    step();
    check("R1 fw default lines", irq_out, 3'b111);
    check("R1 rdata default", cfg_rdata, 8'h07);

    // R5 / R7 firmware sweep
    hw_en = 3'b000; pm_compat = 1'b1;
    for (int v = 0; v < 8; v++) begin
      write_cfg(8'(v));
      step();
      check("R5 fw value on pins", irq_out, v);
      check("R7 readback of fw pins", cfg_rdata, v);
    end

    // R2 R3 R9 R10: all modes and polarities on line 0
    hw_en = 3'b111;
    for (int p = 0; p < 2; p++) begin
      for (int code = 0; code < 8; code++) begin
        write_cfg(8'((p << 6) | (code << 3) | 7));
        step();
        check("R7 stored mode/pol", int'(cfg_rdata[7:3]), (p << 3) | code);
        idle = (exp_width(code) != 0) ? logic'(p == 0) : logic'(p);
        check("R3 idle level", irq_out[0], idle);
        measure(-1, idle, n);
        if (code >= 6) check("R9 reserved code acts as level", n, 0);
        else           check("R2 R10 pulse width", n, exp_width(code));
      end
    end

    // R8 retrigger: width 8, second strobe three cycles later -> 11
    write_cfg(8'h27);
    step();
    measure(3, 1'b1, n);
    check("R8 retrigger length", n, 11);

    // R4 level mode, both polarities; R7 readback with hardware lines
    for (int p = 0; p < 2; p++) begin
      write_cfg(8'((p << 6) | 7));
      for (int v = 0; v < 8; v++) begin
        obf = 3'(v);
        step();
        check("R4 level output", irq_out, (p != 0) ? (~v & 7) : v);
        check("R7 rdata pins under hw", int'(cfg_rdata[2:0]), int'(irq_out));
      end
    end
    obf = '0;

    // R6 power-management line source
    hw_en = 3'b000;
    write_cfg(8'h00);
    pm_compat = 1'b0; obf = 3'b100;
    step(); step();
    check("R6 pm line hw when not compat", irq_out, 3'b100);
    pm_compat = 1'b1;
    step();
    check("R6 pm line fw when compat", irq_out, 3'b000);
    write_cfg(8'h04); obf = 3'b000;
    step();
    check("R6 pm line fw bit set", irq_out, 3'b100);

    // R7 bit 7 never stored
    write_cfg(8'hFF);
    step();
    check("R7 bit7 reads zero", int'(cfg_rdata[7]), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule